// File: doc/BRIEF.md
# Inverter Square-Wave Gate Timing Generator

This block generates the two complementary drive phases for a low-frequency H-bridge or push-pull inverter. It runs from a 1 MHz timing clock, so one count is one microsecond. A single period counter runs from zero to the programmed period length minus one, then wraps. The first part of each period is the positive segment and the rest is the negative segment. A guard interval, with both phases off, is taken out of the start of each segment. Each polarity change therefore gets a both-off gap, and the total period length does not change.

Software programs the period, the length of the positive segment and the guard length. Programming the segment length gives balanced or asymmetric waveforms. A short guard of a few counts suits resistive loads, and a wider guard of 5 to 10 counts suits inductive loads. New values are captured only when the counter wraps, so a change never cuts a pulse short. Taking enable low forces both phases off and restarts the counter from zero.

Top module: `sq_inverter_timer`

## Requirements
- R1: While `rst` is high, both `drv_pos` and `drv_neg` are low.
- R2: With the configuration held steady, `drv_pos` rises exactly once every P clocks, where P is `period_cnt`. A `period_cnt` below 2 is treated as 2.
- R3: Let S be the segment length (`seg_a_cnt` limited to P) and G be `guard_cnt`. Each period, `drv_pos` is high for S−G consecutive clocks and `drv_neg` is high for P−S−G consecutive clocks.
- R4: Between the fall of one phase and the rise of the other, both outputs are low for exactly G clocks. This holds in both directions.
- R5: `drv_pos` and `drv_neg` are never high in the same clock cycle.
- R6: If G is not less than a segment's length, the phase belonging to that segment stays low for the whole period.
- R7: A change to `period_cnt`, `seg_a_cnt` or `guard_cnt` while running does not alter the period in progress. It takes effect from the next counter wrap.
- R8: When `enable` is low at a clock edge, both outputs are low after that edge. When `enable` returns high, the counter restarts at zero, and `drv_pos` first rises G+1 edges after the first edge that sees `enable` high.
- R9: With P=16667, S=8333 and G=2 (60 Hz from a 1 MHz clock), each period has 8331 positive clocks and 8332 negative clocks.
- R10: With P=2500, S=1250 and G=8 (400 Hz with an inductive-load guard), the period is exactly 2500 clocks and each phase is high for 1242 clocks.
- R11: A `seg_a_cnt` larger than P is limited to P, so `drv_neg` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz timing clock, one count per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low forces both phases off and clears the counter |
| period_cnt | input | CNT_W | Period length in counts |
| seg_a_cnt | input | CNT_W | Positive segment length in counts, including its guard |
| guard_cnt | input | CNT_W | Both-off guard length at the start of each segment |
| drv_pos | output | 1 | Registered drive for the positive switch pair |
| drv_neg | output | 1 | Registered drive for the negative switch pair |

## Verification
The case to watch is a configuration write that arrives in the middle of a period, while the counter is still working toward the wrap that will load it. The bench changes the segment length while `drv_pos` is high. It then checks that the remaining positive pulse and the following negative pulse keep their old widths, and that only the next period shows the new split. A second case drops `enable` during a live period. The bench expects both outputs off after the very next edge, and the first positive rise exactly G+1 edges after `enable` returns.

// File: rtl/itg_pkg.sv
package itg_pkg;
  // Smallest period that can still hold one count per segment.
  localparam int MIN_PERIOD = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_POS  = 2'd1,
    PH_NEG  = 2'd2
  } phase_e;
endpackage

// File: rtl/itg_cfg_shadow.sv
module itg_cfg_shadow
  import itg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 16667,
  parameter int DEF_SEG    = 8333,
  parameter int DEF_GUARD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] seg_i,
  input  logic [CNT_W-1:0] guard_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] seg_o,
  output logic [CNT_W-1:0] guard_o
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] DEF_S = CNT_W'(DEF_SEG);
  localparam logic [CNT_W-1:0] DEF_G = CNT_W'(DEF_GUARD);

  logic [CNT_W-1:0] per_lim;
  logic [CNT_W-1:0] seg_lim;

  // Limit the incoming values so the decoder never sees an impossible split.
  always_comb begin
    per_lim = (period_i < MIN_P) ? MIN_P : period_i;
    seg_lim = (seg_i > per_lim) ? per_lim : seg_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_o <= DEF_P;
      seg_o    <= DEF_S;
      guard_o  <= DEF_G;
    end else if (load_i) begin
      period_o <= per_lim;
      seg_o    <= seg_lim;
      guard_o  <= guard_i;
    end
  end
endmodule

// File: rtl/itg_period_counter.sv
module itg_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign wrap_o = run_i && (count_o == period_i - ONE);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      count_o <= '0;
    end else if (wrap_o) begin
      count_o <= '0;
    end else begin
      count_o <= count_o + ONE;
    end
  end

  // The count must stay inside the period that the shadow register holds.
  assert_count_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    count_o < period_i);
endmodule

// File: rtl/itg_phase_decode.sv
module itg_phase_decode
  import itg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] seg_i,
  input  logic [CNT_W-1:0] guard_i,
  output logic             pos_o,
  output logic             neg_o
);
  localparam int XW = CNT_W + 1;

  logic [XW-1:0] cnt_x;
  logic [XW-1:0] neg_start;
  phase_e        phase_d;

  // The guard is taken from the head of each segment; the negative segment
  // begins at seg_i, so its drive begins guard_i counts later.
  always_comb begin
    cnt_x     = {1'b0, count_i};
    neg_start = {1'b0, seg_i} + {1'b0, guard_i};
    phase_d   = PH_IDLE;
    if (run_i) begin
      if ((count_i >= guard_i) && (count_i < seg_i)) begin
        phase_d = PH_POS;
      end else if (cnt_x >= neg_start) begin
        phase_d = PH_NEG;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o <= 1'b0;
      neg_o <= 1'b0;
    end else begin
      pos_o <= (phase_d == PH_POS);
      neg_o <= (phase_d == PH_NEG);
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(pos_o && neg_o));

  assert_stop_off_R8: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!pos_o && !neg_o));
endmodule

// File: rtl/sq_inverter_timer.sv
module sq_inverter_timer #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 16667,
  parameter int DEF_SEG    = 8333,
  parameter int DEF_GUARD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] period_cnt,
  input  logic [CNT_W-1:0] seg_a_cnt,
  input  logic [CNT_W-1:0] guard_cnt,
  output logic             drv_pos,
  output logic             drv_neg
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] seg_q;
  logic [CNT_W-1:0] guard_q;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             cfg_load;

  // Capture new settings while stopped or at the period boundary only.
  assign cfg_load = !enable || wrap;

  itg_cfg_shadow #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
    .DEF_SEG(DEF_SEG), .DEF_GUARD(DEF_GUARD)
  ) u_cfg (
    .clk(clk), .rst(rst), .load_i(cfg_load),
    .period_i(period_cnt), .seg_i(seg_a_cnt), .guard_i(guard_cnt),
    .period_o(period_q), .seg_o(seg_q), .guard_o(guard_q)
  );

  itg_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(enable),
    .period_i(period_q), .count_o(count), .wrap_o(wrap)
  );

  itg_phase_decode #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .run_i(enable),
    .count_i(count), .seg_i(seg_q), .guard_i(guard_q),
    .pos_o(drv_pos), .neg_o(drv_neg)
  );

  // While running, the active settings move only when the counter wraps.
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && !wrap) |=> ($stable(period_q) && $stable(seg_q) && $stable(guard_q)));
endmodule

// File: tb/sq_inverter_timer_tb.sv
`timescale 1ns/1ps
module sq_inverter_timer_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         enable;
  logic [W-1:0] period_cnt;
  logic [W-1:0] seg_a_cnt;
  logic [W-1:0] guard_cnt;
  logic         drv_pos;
  logic         drv_neg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sq_inverter_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable),
    .period_cnt(period_cnt), .seg_a_cnt(seg_a_cnt), .guard_cnt(guard_cnt),
    .drv_pos(drv_pos), .drv_neg(drv_neg)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic apply_cfg(input int p, input int s, input int g);
    @(negedge clk);
    enable     = 1'b0;
    period_cnt = W'(p);
    seg_a_cnt  = W'(s);
    guard_cnt  = W'(g);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Samples n negedges; reports high counts, overlaps, rise spacing and guard gaps.
  task automatic measure(input int n, output int a1, output int b1, output int ovl,
                         output int pa, output int pb, output int gab, output int gba);
    int fa, fb, afall, bfall;
    logic pa_prev, pb_prev;
    a1 = 0; b1 = 0; ovl = 0; pa = -1; pb = -1; gab = -1; gba = -1;
    fa = -1; fb = -1; afall = -1; bfall = -1;
    pa_prev = drv_pos; pb_prev = drv_neg;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (drv_pos) a1++;
      if (drv_neg) b1++;
      if (drv_pos && drv_neg) ovl++;
      if (!drv_pos && pa_prev) afall = i;
      if (!drv_neg && pb_prev) bfall = i;
      if (drv_pos && !pa_prev) begin
        if (fa < 0) fa = i; else if (pa < 0) pa = i - fa;
        if (bfall >= 0) gba = i - bfall;
      end
      if (drv_neg && !pb_prev) begin
        if (fb < 0) fb = i; else if (pb < 0) pb = i - fb;
        if (afall >= 0) gab = i - afall;
      end
      pa_prev = drv_pos; pb_prev = drv_neg;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; enable = 1'b1;
    period_cnt = W'(20); seg_a_cnt = W'(10); guard_cnt = W'(0);
    repeat (4) @(negedge clk);
    chk("R1", "pos in reset", int'(drv_pos), 0);
    chk("R1", "neg in reset", int'(drv_neg), 0);
    rst = 1'b0;
  endtask

  task automatic t_balanced;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(20, 10, 2);
    measure(60, a1, b1, ovl, pa, pb, gab, gba);
    chk("R2", "balanced period", pa, 20);
    chk("R3", "balanced pos ones", a1, 24);
    chk("R3", "balanced neg ones", b1, 24);
    chk("R4", "pos->neg gap", gab, 2);
    chk("R4", "neg->pos gap", gba, 2);
    chk("R5", "balanced overlap", ovl, 0);
  endtask

  task automatic t_asym;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(30, 8, 3);
    measure(90, a1, b1, ovl, pa, pb, gab, gba);
    chk("R2", "asym period", pa, 30);
    chk("R3", "asym pos ones", a1, 15);
    chk("R3", "asym neg ones", b1, 57);
    chk("R4", "asym pos->neg gap", gab, 3);
    chk("R4", "asym neg->pos gap", gba, 3);
  endtask

  task automatic t_guard_swallows;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(20, 4, 5);
    measure(60, a1, b1, ovl, pa, pb, gab, gba);
    chk("R6", "pos stays off", a1, 0);
    chk("R6", "neg ones", b1, 33);
    chk("R2", "neg rise spacing", pb, 20);
  endtask

  task automatic t_zero_guard;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(10, 5, 0);
    measure(40, a1, b1, ovl, pa, pb, gab, gba);
    chk("R5", "zero guard overlap", ovl, 0);
    chk("R4", "zero guard gap", gab, 0);
    chk("R3", "zero guard pos ones", a1, 20);
  endtask

  task automatic t_boundary;
    int run;
    apply_cfg(20, 10, 2);
    while (!drv_pos) @(negedge clk);
    seg_a_cnt = W'(16);
    run = 0;
    while (drv_pos) begin run++; @(negedge clk); end
    chk("R7", "pos run in current period", run, 8);
    while (!drv_neg) @(negedge clk);
    run = 0;
    while (drv_neg) begin run++; @(negedge clk); end
    chk("R7", "neg run in current period", run, 8);
    while (!drv_pos) @(negedge clk);
    run = 0;
    while (drv_pos) begin run++; @(negedge clk); end
    chk("R7", "pos run after wrap", run, 14);
    while (!drv_neg) @(negedge clk);
    run = 0;
    while (drv_neg) begin run++; @(negedge clk); end
    chk("R7", "neg run after wrap", run, 2);
  endtask

  task automatic t_enable;
    int seen;
    apply_cfg(20, 10, 2);
    repeat (7) @(negedge clk);
    enable = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (drv_pos || drv_neg) seen++;
    end
    chk("R8", "outputs while disabled", seen, 0);
    enable = 1'b1;
    @(negedge clk); chk("R8", "pos after edge 1", int'(drv_pos), 0);
    @(negedge clk); chk("R8", "pos after edge 2", int'(drv_pos), 0);
    @(negedge clk); chk("R8", "pos after edge 3", int'(drv_pos), 1);
  endtask

  task automatic t_60hz;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(16667, 8333, 2);
    measure(33334, a1, b1, ovl, pa, pb, gab, gba);
    chk("R9", "60Hz period", pa, 16667);
    chk("R9", "60Hz pos ones", a1, 16662);
    chk("R9", "60Hz neg ones", b1, 16664);
  endtask

  task automatic t_400hz;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(2500, 1250, 8);
    measure(5000, a1, b1, ovl, pa, pb, gab, gba);
    chk("R10", "400Hz period", pa, 2500);
    chk("R10", "400Hz pos ones", a1, 2484);
    chk("R10", "400Hz neg ones", b1, 2484);
    chk("R10", "400Hz guard", gab, 8);
  endtask

  task automatic t_limits;
    int a1, b1, ovl, pa, pb, gab, gba;
    apply_cfg(1, 1, 0);
    measure(10, a1, b1, ovl, pa, pb, gab, gba);
    chk("R2", "short period raised to 2", pa, 2);
    chk("R2", "short period pos ones", a1, 5);
    apply_cfg(12, 40, 1);
    measure(36, a1, b1, ovl, pa, pb, gab, gba);
    chk("R11", "oversized seg neg ones", b1, 0);
    chk("R11", "oversized seg pos ones", a1, 33);
    chk("R11", "oversized seg period", pa, 12);
  endtask

  initial begin
    t_reset();
    t_balanced();
    t_asym();
    t_guard_swallows();
    t_zero_guard();
    t_boundary();
    t_enable();
    t_400hz();
    t_60hz();
    t_limits();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule